// File: doc/BRIEF.md
# Serial Receive Queue with Register Access

This block is the receive half of a serial port's register file. A deserializer hands it bytes on a valid/data strobe, along with per-byte parity and framing error flags, and it raises a separate strobe when the line is held in break. Software reaches the block through a small register port. Through that port it can switch between a queued mode and a single-byte holding mode. It can also drain received bytes, read the queue occupancy and read-and-clear the accumulated line errors.

In queued mode, bytes go into a 16-entry byte queue. The queue tracks occupancy with wrapping store and retrieve pointers that carry one extra bit. In holding mode, each new byte replaces the previous one in a single register. The block emits a one-cycle receive pulse and a one-cycle error pulse, and an interrupt controller outside the block is expected to mask and combine them. The register read port is combinational for the selected address. Read side effects, such as popping a byte or clearing the error flags, take place at the clock edge that ends the read strobe.

Top module: `rx_fifo_regs`

## Requirements
- R1: The control register (address 0) holds the queue enable in bit 0 and stores bits 7..3 as written. Bit 1 (receive queue flush) and bit 2 (transmit queue flush) always read back 0. Writing bit 1 as 1 empties the receive queue.
- R2: The queue status register (address 3) gives the occupancy in bits 7..0 and a full flag in bit 8. When all 16 entries are used, it reads 0x100, so the count field shows 0.
- R3: In queued mode, reading the data register (address 4) returns and removes the oldest byte, in arrival order. The data-ready flag (bit 0 of the line status register, address 1) stays 1 while bytes remain and becomes 0 when the queue is empty.
- R4: In queued mode, reading the data register while the queue is empty returns 0, changes no occupancy, and pulses err_event in the following cycle.
- R5: In queued mode, each stored data byte sets data-ready and pulses rx_event in the following cycle. A byte that arrives while the queue is full is discarded: the contents stay as they were, err_event pulses, and error status bit 0 (overrun) is set.
- R6: In holding mode (control bit 0 = 0), each incoming byte replaces the held byte, sets data-ready and pulses rx_event. Reading the data register returns the held byte and clears data-ready, unless a new byte arrives in the same cycle.
- R7: A break strobe stores a 0x00 byte, into the queue in queued mode or into the holding register in holding mode, and sets error status bit 3. A data byte presented in the same cycle is ignored, and no rx_event is produced for the break.
- R8: The error status register (address 2) has overrun in bit 0, parity in bit 1, frame in bit 2 and break in bit 3. A read returns the current value and then clears it. A flag that is raised in the same cycle as the read survives the clear.
- R9: After reset the line status register reads 0x0006 (both transmit-empty flags at bits 1 and 2 set, data-ready clear). The control, error and queue status registers read 0, and unmapped addresses always read 0.
- R10: A byte arrival and a data register read in the same cycle are both honoured in queued mode, including when the queue is full. The occupancy is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| rx_valid | input | 1 | Received byte strobe from the deserializer |
| rx_data | input | 8 | Received byte |
| rx_parity_err | input | 1 | Parity error flag qualified by rx_valid |
| rx_frame_err | input | 1 | Framing error flag qualified by rx_valid |
| rx_break | input | 1 | Break condition strobe |
| rx_event | output | 1 | One-cycle pulse after a byte is accepted |
| err_event | output | 1 | One-cycle pulse after an overrun or an empty read |

## Verification
A pointer that is off by one, or a lost wrap bit, shows up as a wrong byte, or as a wrong count at the full boundary, on the very next data or queue status read. The bench therefore compares every read against a queue model and fills the queue right up to the 0x100 reading. An error or ready flag that is stuck or cleared at the wrong time becomes visible on the next error or line status read. A mistimed event shows up one cycle after the triggering strobe, which is why both pulses are compared after every single step.

// File: rtl/rx_fifo_regs.sv
module rx_fifo_regs #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_parity_err,
  input  logic        rx_frame_err,
  input  logic        rx_break,
  output logic        rx_event,
  output logic        err_event
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [2:0] A_CTRL = 3'd0, A_LSTAT = 3'd1, A_ERR = 3'd2,
                         A_FSTAT = 3'd3, A_DATA = 3'd4;

  logic [7:0]  ctrl;
  logic [AW:0] wp, rp;
  logic [7:0]  mem [DEPTH];
  logic [7:0]  hold;
  logic        hold_rdy;
  logic [3:0]  err;

  wire         fifo_en  = ctrl[0];
  wire [AW:0]  count    = wp - rp;
  wire         empty    = (count == '0);
  wire         full     = (count == (AW+1)'(DEPTH));
  wire         wr_ctrl  = bus_wr && bus_addr == A_CTRL;
  wire         rx_clr   = wr_ctrl && bus_wdata[1];
  wire         rd_data  = bus_rd && bus_addr == A_DATA;
  wire         rd_err   = bus_rd && bus_addr == A_ERR;
  wire         in_v     = rx_valid | rx_break;
  wire [7:0]   in_b     = rx_break ? 8'h00 : rx_data;
  wire         pop      = fifo_en && rd_data && !empty;
  wire         under    = fifo_en && rd_data && empty;
  wire         push     = fifo_en && in_v && (!full || pop);
  wire         drop     = fifo_en && in_v && full && !pop;
  wire         drdy     = fifo_en ? !empty : hold_rdy;
  wire [3:0]   err_set  = {rx_break, rx_valid & rx_frame_err,
                           rx_valid & rx_parity_err, drop};

  always_ff @(posedge clk) begin
    if (push && !rx_clr) mem[wp[AW-1:0]] <= in_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      wp        <= '0;
      rp        <= '0;
      hold      <= '0;
      hold_rdy  <= 1'b0;
      err       <= '0;
      rx_event  <= 1'b0;
      err_event <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= {bus_wdata[7:3], 2'b00, bus_wdata[0]};
      if (rx_clr) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (push) wp <= wp + 1'b1;
        if (pop)  rp <= rp + 1'b1;
      end
      if (!fifo_en && in_v) begin
        hold     <= in_b;
        hold_rdy <= 1'b1;
      end else if (!fifo_en && rd_data) begin
        hold_rdy <= 1'b0;
      end
      err       <= (rd_err ? 4'h0 : err) | err_set;
      rx_event  <= rx_valid && !rx_break && (fifo_en ? push : 1'b1);
      err_event <= drop || under;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {8'h00, ctrl};
      A_LSTAT: bus_rdata = {13'h0, 2'b11, drdy};
      A_ERR:   bus_rdata = {12'h0, err};
      A_FSTAT: bus_rdata = {7'h0, full, full ? 8'h00 : 8'(count)};
      A_DATA:  bus_rdata = {8'h00, fifo_en ? (empty ? 8'h00 : mem[rp[AW-1:0]]) : hold};
      default: bus_rdata = 16'h0000;
    endcase
  end

  assert_ctrl_selfclear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl[2:1] == 2'b00 && ctrl[0] == $past(bus_wdata[0])));
  assert_flush_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (wp == rp));
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));
  assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !rx_clr) |=> (rp == $past(rp) + 1'b1));
  assert_underrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (under && !rx_clr) |=> (err_event && rp == $past(rp)));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !rx_clr) |=> (err_event && wp == $past(wp) && err[0]));
  assert_break_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> err[3]);
  assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err && !rx_valid && !rx_break && !drop) |=> (err == 4'h0));
  assert_both_honoured_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !rx_clr) |=> (count == $past(count)));
endmodule

// File: tb/sim_rx_fifo_regs.sv
module sim_rx_fifo_regs;
  localparam int DEPTH = 16;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic rx_valid = 0, rx_parity_err = 0, rx_frame_err = 0, rx_break = 0;
  logic [7:0] rx_data = 0;
  logic rx_event, err_event;

  rx_fifo_regs #(.DEPTH(DEPTH)) u0 (.*);

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0] q[$];
  logic [7:0] m_ctrl = 0, m_hold = 0;
  bit m_hrdy = 0;
  logic [3:0] m_err = 0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(logic [2:0] a);
    bit en = m_ctrl[0];
    case (a)
      3'd0: return {8'h00, m_ctrl};
      3'd1: return {13'h0, 2'b11, en ? (q.size() > 0) : m_hrdy};
      3'd2: return {12'h0, m_err};
      3'd3: return (q.size() == DEPTH) ? 16'h0100 : 16'(q.size());
      3'd4: return {8'h00, en ? (q.size() > 0 ? q[0] : 8'h00) : m_hold};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic step(string tag, bit wr, bit rd, logic [2:0] a, logic [7:0] wd,
                      bit rxv, logic [7:0] rxd, bit brk, bit pe, bit fe);
    logic [15:0] er;
    bit en, rdd, inv, pop_ok, under, drop, acc, e_rx, e_err;
    logic [7:0] inb;
    logic [3:0] eset;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    rx_valid = rxv; rx_data = rxd; rx_break = brk; rx_parity_err = pe; rx_frame_err = fe;
    #1;
    er = exp_read(a);
    if (rd) chk(tag, bus_rdata, er);
    en = m_ctrl[0]; rdd = rd && a == 3'd4; inv = rxv | brk;
    inb = brk ? 8'h00 : rxd;
    pop_ok = 0; under = 0; drop = 0; acc = 0;
    if (en) begin
      pop_ok = rdd && q.size() > 0;
      under  = rdd && q.size() == 0;
      if (inv) begin
        if (q.size() < DEPTH || pop_ok) acc = 1; else drop = 1;
      end
      if (pop_ok) void'(q.pop_front());
      if (acc) q.push_back(inb);
      e_rx = rxv && !brk && acc;
    end else begin
      if (inv) begin m_hold = inb; m_hrdy = 1; end
      else if (rdd) m_hrdy = 0;
      e_rx = rxv && !brk;
    end
    e_err = drop || under;
    eset = {brk, rxv & fe, rxv & pe, drop};
    m_err = ((rd && a == 3'd2) ? 4'h0 : m_err) | eset;
    if (wr && a == 3'd0) begin
      if (wd[1]) q.delete();
      m_ctrl = {wd[7:3], 2'b00, wd[0]};
    end
    @(posedge clk); @(negedge clk);
    bus_wr = 0; bus_rd = 0; rx_valid = 0; rx_break = 0; rx_parity_err = 0; rx_frame_err = 0;
    chk({tag, " rx_event"}, {15'h0, rx_event}, {15'h0, e_rx});
    chk({tag, " err_event"}, {15'h0, err_event}, {15'h0, e_err});
  endtask

  task automatic rd(string tag, logic [2:0] a);
    step(tag, 0, 1, a, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic wr(string tag, logic [2:0] a, logic [7:0] d);
    step(tag, 1, 0, a, d, 0, 0, 0, 0, 0);
  endtask
  task automatic rx(string tag, logic [7:0] d);
    step(tag, 0, 0, 0, 0, 1, d, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset values
    for (int a = 0; a < 8; a++) rd("R9 reset read", 3'(a));
    // R5 fill queue to full
    wr("R1 enable", 3'd0, 8'h01);
    for (int i = 0; i < DEPTH; i++) rx("R5 accept", 8'(8'h30 + i));
    rd("R2 full reads 0x100", 3'd3);
    rd("R3 ready while full", 3'd1);
    rx("R5 overrun drop", 8'hEE);
    rd("R8 overrun flag", 3'd2);
    rd("R8 cleared after read", 3'd2);
    // R10 simultaneous arrival and pop while full
    step("R10 pop+push at full", 0, 1, 3'd4, 0, 1, 8'hA5, 0, 0, 0);
    rd("R10 count unchanged", 3'd3);
    for (int i = 0; i < DEPTH; i++) begin
      rd("R3 drain order", 3'd4);
      rd("R3 ready flag", 3'd1);
    end
    rd("R4 empty read returns 0", 3'd4);
    rd("R2 empty count", 3'd3);
    // R7 break
    step("R7 break with data", 0, 0, 0, 0, 1, 8'h77, 1, 0, 0);
    rd("R7 break flag", 3'd2);
    rd("R7 zero byte", 3'd4);
    // R8 parity/frame and set during read
    step("R8 parity", 0, 0, 0, 0, 1, 8'h11, 0, 1, 0);
    step("R8 read while frame err", 0, 1, 3'd2, 0, 1, 8'h12, 0, 0, 1);
    rd("R8 frame survives", 3'd2);
    // R1 flush
    rx("R1 pre-flush", 8'h01);
    wr("R1 flush", 3'd0, 8'hFF);
    rd("R1 readback", 3'd0);
    rd("R1 queue empty", 3'd3);
    rd("R1 ready clear", 3'd1);
    // R6 holding mode
    wr("R6 holding mode", 3'd0, 8'h00);
    rx("R6 first", 8'h5A);
    rx("R6 overwrite", 8'hC3);
    rd("R6 ready", 3'd1);
    rd("R6 held byte", 3'd4);
    rd("R6 ready cleared", 3'd1);
    step("R6 read with arrival", 0, 1, 3'd4, 0, 1, 8'h9C, 0, 0, 0);
    rd("R6 ready kept", 3'd1);
    step("R7 break holding", 0, 0, 0, 0, 0, 0, 1, 0, 0);
    rd("R7 holding zero", 3'd4);
    // random phase
    void'($urandom(32'd4242));
    for (int i = 0; i < 1200; i++) begin
      int r;
      if (i == 0)   wr("R1 random enable", 3'd0, 8'h01);
      if (i == 800) wr("R6 random holding", 3'd0, 8'h00);
      r = $urandom_range(99);
      if (r < 40)
        step("R5 random rx", 0, 0, 0, 0, 1, 8'($urandom),
             ($urandom_range(19) == 0), ($urandom_range(9) == 0), ($urandom_range(9) == 0));
      else if (r < 70) rd("R3 random data", 3'd4);
      else if (r < 80) step("R10 random both", 0, 1, 3'd4, 0, 1, 8'($urandom), 0, 0, 0);
      else if (r < 88) rd("R2 random status", 3'd3);
      else if (r < 94) rd("R8 random err", 3'd2);
      else rd("R3 random ready", 3'd1);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule